// File: doc/BRIEF.md
# Memory Rank Sparing Controller

This block sits between a host request port and a memory port that serves several ranks. The rank with the highest index is held back as a spare, so the host sees only the other ranks. Rank `i` is the address range whose upper address bits equal `i`. An external ECC checker reports correctable errors with a physical rank tag. The block keeps a saturating count of these errors for each host-visible rank.

When one of those counts rises above a programmable threshold, a background sequencer copies every word of that rank into the spare. It reads one word and then writes it to the spare, and it uses the memory port only in cycles the host leaves free. Host writes to the failing rank that arrive during the copy still reach the spare, so the copy cannot go stale. When the last word is written, all later host accesses to the failing rank go to the spare instead. This remap is permanent.

Only one sparing event is possible. A threshold crossing after the spare has been claimed sets a sticky flag and starts no new copy. Until the first event, host requests reach the memory port in the same cycle, with no stall.

Top module: `rank_spare_ctrl`

## Requirements
- R1: `usable_words` equals (NUM_RANKS-1)·2^OFF_W. Until a sparing event starts, the memory port never addresses the spare rank (physical index NUM_RANKS-1) and `spare_active` is 0.
- R2: Before any sparing event, `h_ready` is 1. A host request appears on the memory port in the same cycle, with `m_addr` = {rank zero-extended to PRK_W bits, offset} and the same write flag and data. A read returns `h_rdata` with `h_rvalid` high one cycle after it is accepted (memory answers reads one cycle later).
- R3: A pulse on `ecc_ce` increments the counter of rank `ecc_rank` when that rank is below NUM_RANKS-1. Reports tagged with the spare index are ignored. Counters saturate at 2^CNT_W-1 and do not wrap.
- R4: A counter equal to `thresh` starts nothing. A counter greater than `thresh` sets `copy_busy` and `spare_active` within two cycles, and `failed_rank` shows that rank.
- R5: The copy writes every offset of the failing rank into the spare rank. It uses the memory port only in cycles with no host request.
- R6: Host writes to the failing rank during the copy are present in the spare when the copy ends.
- R7: After the copy, `copy_busy` is 0 and `copy_done` is 1. Host accesses to `failed_rank` are sent to physical rank NUM_RANKS-1, and other ranks are unchanged.
- R8: A threshold crossing after the spare is claimed sets `spare_exhausted`, which stays set. It starts no second copy and leaves `failed_rank` unchanged.
- R9: During the copy, a host write to an already-copied offset of the failing rank is followed by one cycle with `h_ready` low. In that cycle the same data is written to the spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | CNT_W | Error-count threshold (trip when count > thresh) |
| ecc_ce | input | 1 | Correctable-error pulse from the ECC checker |
| ecc_rank | input | PRK_W | Physical rank of the reported error |
| h_req | input | 1 | Host request valid |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | LRK_W+OFF_W | Host address {rank, offset} |
| h_wdata | input | DW | Host write data |
| h_ready | output | 1 | Host request accepted this cycle |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | DW | Host read data |
| m_req | output | 1 | Memory request |
| m_we | output | 1 | Memory write |
| m_addr | output | PRK_W+OFF_W | Physical address {rank, offset} |
| m_wdata | output | DW | Memory write data |
| m_rdata | input | DW | Memory read data, one cycle after the read |
| spare_active | output | 1 | Spare has been claimed |
| copy_busy | output | 1 | Copy in progress |
| copy_done | output | 1 | Remap in effect |
| spare_exhausted | output | 1 | Sticky: a crossing occurred after the spare was claimed |
| failed_rank | output | LRK_W | Index of the retired rank |
| usable_words | output | LRK_W+OFF_W+1 | Host-visible capacity in words |

## Verification
The bench builds the block with five ranks, eight words per rank, 16-bit data and 3-bit counters. With eight words per rank, a full copy finishes in a few dozen cycles. That makes it possible to predict which offsets are already copied when host writes land at chosen points during the copy, covering both the buffer-override case and the mirrored-write stall. The 3-bit counters reach saturation after only a handful of error pulses. Lowering the threshold below the saturated value then shows whether a counter wrapped, and the same step exercises the exhausted flag.

// File: rtl/rank_spare_ctrl.sv
module rank_spare_ctrl #(
  parameter int NUM_RANKS = 5,
  parameter int OFF_W     = 3,
  parameter int DW        = 16,
  parameter int CNT_W     = 3,
  localparam int NUM_ACT  = NUM_RANKS - 1,
  localparam int LRK_W    = (NUM_ACT > 1) ? $clog2(NUM_ACT) : 1,
  localparam int PRK_W    = $clog2(NUM_RANKS),
  localparam int HAW      = LRK_W + OFF_W,
  localparam int PAW      = PRK_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thresh,
  input  logic             ecc_ce,
  input  logic [PRK_W-1:0] ecc_rank,
  input  logic             h_req,
  input  logic             h_we,
  input  logic [HAW-1:0]   h_addr,
  input  logic [DW-1:0]    h_wdata,
  output logic             h_ready,
  output logic             h_rvalid,
  output logic [DW-1:0]    h_rdata,
  output logic             m_req,
  output logic             m_we,
  output logic [PAW-1:0]   m_addr,
  output logic [DW-1:0]    m_wdata,
  input  logic [DW-1:0]    m_rdata,
  output logic             spare_active,
  output logic             copy_busy,
  output logic             copy_done,
  output logic             spare_exhausted,
  output logic [LRK_W-1:0] failed_rank,
  output logic [HAW:0]     usable_words
);
  localparam logic [PRK_W-1:0] SPARE    = PRK_W'(NUM_RANKS - 1);
  localparam logic [CNT_W-1:0] CMAX     = '1;
  localparam logic [OFF_W-1:0] OFF_LAST = '1;

  typedef enum logic [1:0] {C_RD, C_WAIT, C_WR} cst_t;

  logic [CNT_W-1:0] cnt [NUM_ACT];
  logic [NUM_ACT-1:0] tripped, over;
  logic [LRK_W-1:0] pick, fail_q;
  logic used_q, busy_q, done_q, exh_q, rv_q, mir_v;
  cst_t cst;
  logic [OFF_W-1:0] ptr, mir_off;
  logic [DW-1:0] cbuf, mir_d;

  wire [LRK_W-1:0] h_rank   = h_addr[HAW-1:OFF_W];
  wire [OFF_W-1:0] h_off    = h_addr[OFF_W-1:0];
  wire             hit_fail = (h_rank == fail_q);
  wire [PRK_W-1:0] h_prank  = (done_q && hit_fail) ? SPARE : PRK_W'(h_rank);
  wire             h_go     = h_req && h_ready;
  wire             h_wfail  = busy_q && h_go && h_we && hit_fail;
  wire             buf_hit  = h_wfail && (h_off == ptr);
  wire             need_mir = h_wfail && (h_off < ptr);
  wire             cp_slot  = busy_q && !mir_v && !h_req;
  wire             cp_rd    = cp_slot && (cst == C_RD);
  wire             cp_wr    = cp_slot && (cst == C_WR);
  wire             any_over = |over;
  wire             multi    = (over & (over - 1'b1)) != '0;

  assign h_ready         = !mir_v;
  assign h_rvalid        = rv_q;
  assign h_rdata         = m_rdata;
  assign spare_active    = used_q;
  assign copy_busy       = busy_q;
  assign copy_done       = done_q;
  assign spare_exhausted = exh_q;
  assign failed_rank     = fail_q;
  assign usable_words    = (HAW+1)'(NUM_ACT) << OFF_W;

  for (genvar i = 0; i < NUM_ACT; i++) begin : g_cnt
    wire inc = ecc_ce && (ecc_rank == PRK_W'(i));
    assign over[i] = (cnt[i] > thresh) && !tripped[i];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[i]     <= '0;
        tripped[i] <= 1'b0;
      end else begin
        if (inc && cnt[i] != CMAX) cnt[i] <= cnt[i] + 1'b1;
        if (over[i]) tripped[i] <= 1'b1;
      end
    end
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[i] == CMAX |=> cnt[i] == CMAX); // R3
  end

  always_comb begin
    pick = '0;
    for (int i = NUM_ACT - 1; i >= 0; i--)
      if (over[i]) pick = LRK_W'(i);
  end

  always_comb begin
    m_req = 1'b0; m_we = 1'b0; m_addr = '0; m_wdata = '0;
    if (mir_v) begin
      m_req = 1'b1; m_we = 1'b1; m_addr = {SPARE, mir_off}; m_wdata = mir_d;
    end else if (h_req) begin
      m_req = 1'b1; m_we = h_we; m_addr = {h_prank, h_off}; m_wdata = h_wdata;
    end else if (cp_rd) begin
      m_req = 1'b1; m_addr = {PRK_W'(fail_q), ptr};
    end else if (cp_wr) begin
      m_req = 1'b1; m_we = 1'b1; m_addr = {SPARE, ptr}; m_wdata = cbuf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0; exh_q <= 1'b0;
      fail_q <= '0; ptr <= '0; cst <= C_RD; cbuf <= '0;
      mir_v <= 1'b0; mir_off <= '0; mir_d <= '0; rv_q <= 1'b0;
    end else begin
      rv_q    <= h_go && !h_we;
      mir_v   <= need_mir;
      mir_off <= h_off;
      mir_d   <= h_wdata;
      if (any_over) begin
        if (!used_q) begin
          used_q <= 1'b1; busy_q <= 1'b1; fail_q <= pick;
          ptr <= '0; cst <= C_RD;
        end
        if (used_q || multi) exh_q <= 1'b1;
      end
      if (busy_q) begin
        case (cst)
          C_RD:   if (cp_rd) cst <= C_WAIT;
          C_WAIT: begin
            cbuf <= buf_hit ? h_wdata : m_rdata;
            cst  <= C_WR;
          end
          C_WR: begin
            if (buf_hit) cbuf <= h_wdata;
            if (cp_wr) begin
              if (ptr == OFF_LAST) begin
                busy_q <= 1'b0; done_q <= 1'b1;
              end else begin
                ptr <= ptr + 1'b1; cst <= C_RD;
              end
            end
          end
          default: cst <= C_RD;
        endcase
      end
    end
  end

  AST_SPARE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!spare_active && m_req) |-> m_addr[PAW-1:OFF_W] != SPARE); // R1
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!spare_active && h_req) |-> (h_ready && m_req && m_we == h_we &&
                                  m_addr[OFF_W-1:0] == h_off)); // R2
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && h_ready && !h_we) |=> h_rvalid); // R2
  AST_REMAP_TO_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_done && h_req && h_ready && h_rank == failed_rank) |->
      m_addr[PAW-1:OFF_W] == SPARE); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |=> (copy_done && !copy_busy && $stable(failed_rank))); // R7
  AST_EXHAUST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    spare_exhausted |=> spare_exhausted); // R8
  AST_MIRROR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_busy && h_req && h_ready && h_we && h_rank == failed_rank && h_off < ptr)
      |=> (!h_ready && m_we && m_addr[PAW-1:OFF_W] == SPARE)); // R9
endmodule

// File: tb/rank_spare_ctrl_test.sv
module rank_spare_ctrl_test;
  localparam int NR = 5, OW = 3, DW = 16, CW = 3;
  localparam int LW = 2, PW = 3, HAW = LW + OW, PAW = PW + OW;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] thresh = '1;
  logic ecc_ce = 0;
  logic [PW-1:0] ecc_rank = '0;
  logic h_req = 0, h_we = 0;
  logic [HAW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic h_ready, h_rvalid, m_req, m_we;
  logic [DW-1:0] h_rdata, m_wdata, m_rdata;
  logic [PAW-1:0] m_addr;
  logic spare_active, copy_busy, copy_done, spare_exhausted;
  logic [LW-1:0] failed_rank;
  logic [HAW:0] usable_words;

  rank_spare_ctrl #(.NUM_RANKS(NR), .OFF_W(OW), .DW(DW), .CNT_W(CW)) uut (.*);

  always #5 clk = ~clk;

  logic [DW-1:0] mem [64];
  always @(posedge clk) if (m_req) begin
    if (m_we) mem[m_addr] <= m_wdata;
    else m_rdata <= mem[m_addr];
  end

  int total = 0, bad = 0;
  logic [DW-1:0] rd;
  logic [PW-1:0] seen_rank;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_op(input bit we, input int rank, input int off, input logic [DW-1:0] d);
    h_req = 1; h_we = we; h_addr = {LW'(rank), OW'(off)}; h_wdata = d;
    #1;
    while (!h_ready) begin @(negedge clk); #1; end
    seen_rank = m_addr[PAW-1:OW];
    @(negedge clk);
    h_req = 0; h_we = 0;
    #1;
    rd = h_rdata;
  endtask

  task automatic ecc_pulse(input int rank, input int n);
    for (int k = 0; k < n; k++) begin
      ecc_ce = 1; ecc_rank = PW'(rank);
      @(negedge clk);
      ecc_ce = 0;
      @(negedge clk);
    end
  endtask

  localparam logic [24:0] VEC [8] = '{
    {1'b1, 2'd0, 3'd2, 16'hA001, 3'd0}, {1'b1, 2'd3, 3'd7, 16'hA002, 3'd3},
    {1'b1, 2'd2, 3'd0, 16'hA003, 3'd2}, {1'b1, 2'd1, 3'd4, 16'hA004, 3'd1},
    {1'b0, 2'd0, 3'd2, 16'hA001, 3'd0}, {1'b0, 2'd3, 3'd7, 16'hA002, 3'd3},
    {1'b0, 2'd2, 3'd0, 16'hA003, 3'd2}, {1'b0, 2'd1, 3'd4, 16'hA004, 3'd1}};

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state and capacity
    chk(usable_words == 32, "R1 capacity", usable_words, 32);
    chk({spare_active, copy_busy, copy_done, spare_exhausted, m_req, h_rvalid} == 0,
        "R1 reset flags", {spare_active, copy_busy, copy_done, spare_exhausted}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R2 vector table: same-cycle pass-through and one-cycle read return
    for (int v = 0; v < 8; v++) begin
      host_op(VEC[v][24], int'(VEC[v][23:22]), int'(VEC[v][21:19]), VEC[v][18:3]);
      chk(seen_rank == VEC[v][2:0], "R2 rank pass-through", seen_rank, VEC[v][2:0]);
      if (!VEC[v][24]) chk(h_rvalid && rd == VEC[v][18:3], "R2 read data", rd, VEC[v][18:3]);
    end

    for (int o = 0; o < 8; o++) host_op(1, 1, o, 16'h1100 + 16'(o));

    // R3/R4: errors at threshold and on spare do not trip
    thresh = 3'd2;
    ecc_pulse(1, 2);
    ecc_pulse(4, 5);
    repeat (3) @(negedge clk);
    #1;
    chk(!copy_busy && !spare_active, "R4 no trip at threshold", copy_busy, 0);
    chk(mem[{3'd4, 3'd0}] == 0, "R1 spare untouched", mem[{3'd4, 3'd0}], 0);
    ecc_pulse(1, 1);
    #1;
    chk(copy_busy && spare_active, "R4 trip above threshold", {spare_active, copy_busy}, 3);
    chk(failed_rank == 1, "R4 failed rank", failed_rank, 1);

    // R6: early writes to the failing rank
    host_op(1, 1, 0, 16'hBEEF);
    host_op(1, 1, 5, 16'h5555);
    repeat (12) @(negedge clk);
    #1;
    chk(copy_busy, "R5 copy still running", copy_busy, 1);
    host_op(1, 1, 0, 16'hCAFE);
    chk(!h_ready, "R9 mirror stall", h_ready, 0);
    @(negedge clk);

    for (int t = 0; t < 200 && !copy_done; t++) @(negedge clk);
    #1;
    chk(copy_done && !copy_busy, "R7 copy finished", {copy_done, copy_busy}, 2);
    chk(failed_rank == 1, "R7 failed rank held", failed_rank, 1);
    for (int o = 0; o < 8; o++) begin
      logic [DW-1:0] e;
      e = (o == 0) ? 16'hCAFE : (o == 5) ? 16'h5555 : 16'h1100 + 16'(o);
      chk(mem[{3'd4, 3'(o)}] == e, (o == 0 || o == 5) ? "R6 spare coherent" : "R5 spare copy",
          mem[{3'd4, 3'(o)}], e);
    end

    host_op(0, 1, 5, '0);
    chk(seen_rank == 4, "R7 remap to spare", seen_rank, 4);
    chk(rd == 16'h5555, "R7 remapped read", rd, 16'h5555);
    host_op(1, 1, 3, 16'h7777);
    chk(seen_rank == 4 && mem[{3'd4, 3'd3}] == 16'h7777, "R7 remapped write", mem[{3'd4, 3'd3}], 16'h7777);
    host_op(0, 0, 2, '0);
    chk(seen_rank == 0 && rd == 16'hA001, "R7 other rank unchanged", rd, 16'hA001);

    // R3 saturation observed through threshold change, R8 exhausted
    thresh = 3'd7;
    ecc_pulse(2, 10);
    repeat (2) @(negedge clk);
    #1;
    chk(!spare_exhausted, "R3 no trip at max threshold", spare_exhausted, 0);
    thresh = 3'd6;
    repeat (3) @(negedge clk);
    #1;
    chk(spare_exhausted, "R3 counter saturated, R8 exhausted set", spare_exhausted, 1);
    chk(!copy_busy && copy_done && failed_rank == 1, "R8 no second copy", failed_rank, 1);
    thresh = 3'd7;
    repeat (3) @(negedge clk);
    #1;
    chk(spare_exhausted, "R8 exhausted sticky", spare_exhausted, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule